// File: doc/BRIEF.md
# LED PWM Generator with Double-Buffered Prescaler

This block drives one active-high LED pin with a pulse-width modulated waveform. Software sets it up through a small word-addressed register port with a single-cycle write strobe and a combinational read. The output period is 256 × (LD + 1) input clocks, where LD is a prescale value. An 8-bit duty value sets how many of the 256 steps in a period the pin is high. A two-bit mode field selects between a forced-low state, PWM and a forced-high state.

Duty changes reach the pin on the next cycle. A prescale change is staged: a write only fills a holding register. Setting the update-request bit in the config word then moves the held value into the active counter at the next period boundary, so a period is never cut short or stretched halfway. A self-clearing soft-reset bit returns the config word and the counting logic to their defaults. The clock-source bit, the watchdog-reload byte, the maximum-limit byte, the high-delay field and the output-delay byte are stored and read back, but they do not alter the waveform.

Top module: `led_pwm_gen`

## Requirements
- R1: After reset the config word (word 0) reads 0x0000_1400, the limits word (1), delay word (2) and output-delay word (5) read 0, and the LED output is low.
- R2: Mode values 0 and 1 in config bits [1:0] hold the LED low and clear the internal step and prescale counters.
- R3: Mode value 3 holds the LED high.
- R4: In mode 2 with duty d in 1..254 (limits bits [7:0]), k input clocks after a period starts the LED is high exactly when floor(k/(LD+1)) mod 256 < d. A period lasts 256 × (LD+1) clocks.
- R5: In mode 2, duty 0 keeps the LED low for the whole period and duty 255 keeps it high for the whole period.
- R6: A write to the limits word changes the LED on the next cycle, without waiting for a period boundary.
- R7: A write to the delay word (prescale in bits [11:0]) only loads the holding register, which reads back from the delay word. The active period length stays the same until a transfer is requested.
- R8: Writing 1 to config bit 6 requests a transfer. Bit 6 reads 1 while it is pending. At the next period boundary the held prescale becomes active, bit 6 clears, and the new period uses the new length.
- R9: Writing 1 to config bit 7 returns config to 0x0000_1400 whatever else was written. It also cancels a pending transfer, clears the counters and sets the active prescale to 0. Limits and delay keep their values.
- R10: Readback fields: config bits [15:8] watchdog reload, bit 2 clock-source select, bits [1:0] mode. Limits reads bits [15:0], delay reads bits [23:0] and output delay reads bits [7:0]. Words 3, 4, 6 and 7 read 0 and ignore writes, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that also paces the PWM counters |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Word index of the register to access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the word at reg_addr (combinational) |
| led_out | output | 1 | Active-high LED drive |

## Verification
The bench builds the block with its default parameters: a 12-bit prescale field and an 8-bit duty. It keeps the prescale values small, from 0 to 2, so a full period lasts only 256 to 768 clocks. At LD = 0 it sweeps every duty value from 1 to 254 in back-to-back periods and checks the pin on each clock. At LD of 1 and 2 it checks a spread of duties, including the forced-low and forced-high codes. Short periods also let the bench count the exact cycle at which a staged prescale takes over, and see that the pattern after a soft reset runs at LD = 0.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 3;
    localparam int DUTY_W  = 8;
    localparam int DLY_FLD = 12;   // width of each delay half-field

    localparam int CFG_CLK_BIT  = 2;
    localparam int CFG_UPD_BIT  = 6;
    localparam int CFG_SRST_BIT = 7;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG  = 3'd0,
        A_LIM  = 3'd1,
        A_DLY  = 3'd2,
        A_STEP = 3'd3,
        A_INTV = 3'd4,
        A_ODLY = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        M_OFF  = 2'd0,
        M_RSVD = 2'd1,
        M_PWM  = 2'd2,
        M_ON   = 2'd3
    } mode_e;

    typedef struct packed {
        logic [7:0] wdt_reload;
        logic       clk_fast;
        mode_e      mode;
    } cfg_t;

    typedef struct packed {
        logic [7:0] max_lvl;
        logic [7:0] duty;
    } lim_t;

    // Pin level for a given mode, step count and duty
    function automatic logic pwm_level(mode_e m, logic [DUTY_W-1:0] step,
                                       logic [DUTY_W-1:0] duty);
        logic lvl;
        case (m)
            M_ON:    lvl = 1'b1;
            M_PWM: begin
                if (duty == '0)      lvl = 1'b0;
                else if (duty == '1) lvl = 1'b1;
                else                 lvl = (step < duty);
            end
            default: lvl = 1'b0;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/led_pwm_regs.sv
module led_pwm_regs
    import led_pwm_pkg::*;
#(
    parameter int         LD_W        = 12,
    parameter logic [7:0] WDT_DEFAULT = 8'h14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              xfer_done,
    output mode_e             mode,
    output logic [DUTY_W-1:0] duty,
    output logic [LD_W-1:0]   ld_hold,
    output logic              xfer_pend,
    output logic              soft_rst
);

    localparam cfg_t CFG_DEFAULT = '{wdt_reload: WDT_DEFAULT, clk_fast: 1'b0, mode: M_OFF};

    cfg_t               cfg_q;
    lim_t               lim_q;
    logic [DLY_FLD-1:0] dly_hi_q;
    logic [7:0]         odly_q;

    logic wr_cfg, wr_lim, wr_dly, wr_odly;

    assign wr_cfg  = reg_wr && (reg_addr == A_CFG);
    assign wr_lim  = reg_wr && (reg_addr == A_LIM);
    assign wr_dly  = reg_wr && (reg_addr == A_DLY);
    assign wr_odly = reg_wr && (reg_addr == A_ODLY);

    assign soft_rst = wr_cfg && reg_wdata[CFG_SRST_BIT];

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            cfg_q <= CFG_DEFAULT;
        end else if (wr_cfg) begin
            cfg_q.wdt_reload <= reg_wdata[15:8];
            cfg_q.clk_fast   <= reg_wdata[CFG_CLK_BIT];
            cfg_q.mode       <= mode_e'(reg_wdata[1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            xfer_pend <= 1'b0;
        else if (wr_cfg && reg_wdata[CFG_UPD_BIT])
            xfer_pend <= 1'b1;
        else if (xfer_done)
            xfer_pend <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q    <= '0;
            ld_hold  <= '0;
            dly_hi_q <= '0;
            odly_q   <= '0;
        end else begin
            if (wr_lim)  lim_q  <= lim_t'(reg_wdata[15:0]);
            if (wr_odly) odly_q <= reg_wdata[7:0];
            if (wr_dly) begin
                ld_hold  <= reg_wdata[LD_W-1:0];
                dly_hi_q <= reg_wdata[2*DLY_FLD-1:DLY_FLD];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG: begin
                reg_rdata[15:8]        = cfg_q.wdt_reload;
                reg_rdata[CFG_UPD_BIT] = xfer_pend;
                reg_rdata[CFG_CLK_BIT] = cfg_q.clk_fast;
                reg_rdata[1:0]         = cfg_q.mode;
            end
            A_LIM:  reg_rdata[15:0] = lim_q;
            A_DLY: begin
                reg_rdata[LD_W-1:0]              = ld_hold;
                reg_rdata[2*DLY_FLD-1:DLY_FLD]   = dly_hi_q;
            end
            A_ODLY: reg_rdata[7:0] = odly_q;
            default: reg_rdata = '0;
        endcase
    end

    assign mode = cfg_q.mode;
    assign duty = lim_q.duty;

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_pend && !xfer_done && !soft_rst) |=> xfer_pend);

    // R9
    srst_default_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (mode == M_OFF && !xfer_pend && reg_wdata !== 'x
                      && cfg_q.wdt_reload == WDT_DEFAULT));

endmodule

// File: rtl/led_pwm_core.sv
module led_pwm_core
    import led_pwm_pkg::*;
#(
    parameter int LD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  mode_e             mode,
    input  logic [DUTY_W-1:0] duty,
    input  logic [LD_W-1:0]   ld_hold,
    input  logic              xfer_pend,
    output logic              xfer_done,
    output logic              led_out
);

    logic [LD_W-1:0]   pre_cnt;
    logic [LD_W-1:0]   ld_act;
    logic [DUTY_W-1:0] step_cnt;
    logic              run, tick, boundary;

    assign run       = (mode == M_PWM);
    assign tick      = run && (pre_cnt == ld_act);
    assign boundary  = tick && (step_cnt == '1);
    assign xfer_done = boundary && xfer_pend;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            pre_cnt  <= '0;
            step_cnt <= '0;
            ld_act   <= '0;
        end else if (!run) begin
            pre_cnt  <= '0;
            step_cnt <= '0;
        end else begin
            if (tick) begin
                pre_cnt  <= '0;
                step_cnt <= step_cnt + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
            if (xfer_done)
                ld_act <= ld_hold;
        end
    end

    assign led_out = pwm_level(mode, step_cnt, duty);

    // R2
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != M_PWM) |=> (step_cnt == '0 && pre_cnt == '0));

    // R7
    ld_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(xfer_done || soft_rst) |=> $stable(ld_act));

    // R4
    step_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && step_cnt != '1 && !soft_rst) |=> step_cnt == $past(step_cnt) + 1'b1);

endmodule

// File: rtl/led_pwm_gen.sv
module led_pwm_gen
    import led_pwm_pkg::*;
#(
    parameter int         LD_W        = 12,
    parameter logic [7:0] WDT_DEFAULT = 8'h14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              led_out
);

    mode_e             mode;
    logic [DUTY_W-1:0] duty;
    logic [LD_W-1:0]   ld_hold;
    logic              xfer_pend, xfer_done, soft_rst;

    led_pwm_regs #(.LD_W(LD_W), .WDT_DEFAULT(WDT_DEFAULT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .xfer_done (xfer_done),
        .mode      (mode),
        .duty      (duty),
        .ld_hold   (ld_hold),
        .xfer_pend (xfer_pend),
        .soft_rst  (soft_rst)
    );

    led_pwm_core #(.LD_W(LD_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .mode      (mode),
        .duty      (duty),
        .ld_hold   (ld_hold),
        .xfer_pend (xfer_pend),
        .xfer_done (xfer_done),
        .led_out   (led_out)
    );

    // R3
    on_high_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_ON) |-> led_out);

    // R5
    full_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_PWM && duty == '1) |-> led_out);

endmodule

// File: tb/led_pwm_gen_bench.sv
`timescale 1ns/100ps
module led_pwm_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = 3'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        led_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    led_pwm_gen u_led_pwm_gen (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .led_out   (led_out)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = 3'd0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.1;
        d = reg_rdata;
        reg_addr = 3'd0;
    endtask

    function automatic logic exp_led(int ld, int d, int k);
        if (d == 0)   return 1'b0;
        if (d == 255) return 1'b1;
        return ((k / (ld + 1)) % 256) < d;
    endfunction

    // wait until the update-request bit reads 0; n = cycles waited
    task automatic wait_xfer(output int n);
        logic [31:0] v;
        n = 0;
        forever begin
            rd(3'd0, v);
            if (v[6] == 1'b0) break;
            @(negedge clk);
            n++;
        end
    endtask

    // check one stretch of cycles from position k0, return high count
    task automatic run_chk(string req, int ld, int d, int k0, int n, output int highs);
        highs = 0;
        for (int k = k0; k < k0 + n; k++) begin
            check(req, {31'd0, led_out}, {31'd0, exp_led(ld, d, k)});
            if (led_out) highs++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n, h;
        int duties[7] = '{1, 37, 128, 200, 254, 0, 255};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check("R1 cfg", v, 32'h0000_1400);
        rd(3'd1, v); check("R1 lim", v, 32'h0);
        rd(3'd2, v); check("R1 dly", v, 32'h0);
        rd(3'd5, v); check("R1 odly", v, 32'h0);
        check("R1 led", {31'd0, led_out}, 32'd0);

        // R10 readback fields
        wr(3'd1, 32'hFFFF_ABCD); rd(3'd1, v); check("R10 lim", v, 32'h0000_ABCD);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); check("R10 dly", v, 32'h00FF_FFFF);
        wr(3'd5, 32'h0000_01FF); rd(3'd5, v); check("R10 odly", v, 32'h0000_00FF);
        wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); check("R10 step", v, 32'h0);
        wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, v); check("R10 intv", v, 32'h0);
        wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, v); check("R10 addr6", v, 32'h0);
        wr(3'd0, 32'hFFFF_5A38); rd(3'd0, v); check("R10 cfg", v, 32'h0000_5A00);
        wr(3'd0, 32'h0000_5A04); rd(3'd0, v); check("R10 cfg clk", v, 32'h0000_5A04);
        wr(3'd2, 32'h0);

        // R2 forced low in modes 0 and 1
        wr(3'd1, 32'd100);
        wr(3'd0, 32'h1);
        run_chk("R2 mode1", 0, 0, 0, 300, h);
        wr(3'd0, 32'h0);
        run_chk("R2 mode0", 0, 0, 0, 300, h);

        // R3 forced high
        wr(3'd0, 32'h3);
        run_chk("R3 mode3", 0, 255, 0, 300, h);

        // R4 every duty 1..254 at LD=0, duty switched at each boundary
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h0);
        wr(3'd1, 32'd1);
        wr(3'd0, 32'h42);
        wait_xfer(n);
        for (int d = 1; d <= 254; d++) begin
            for (int k = 0; k < 256; k++) begin
                check("R4 sweep", {31'd0, led_out}, {31'd0, exp_led(0, d, k)});
                if (k == 255 && d < 254) wr(3'd1, d + 1);
                else @(negedge clk);
            end
        end

        // R4 / R5 at LD 1 and 2, including forced codes
        for (int ld = 1; ld <= 2; ld++) begin
            foreach (duties[i]) begin
                wr(3'd0, 32'h0);
                wr(3'd2, ld);
                wr(3'd1, duties[i]);
                wr(3'd0, 32'h42);
                wait_xfer(n);
                run_chk((duties[i] == 0 || duties[i] == 255) ? "R5 period" : "R4 period",
                        ld, duties[i], 0, 256 * (ld + 1), h);
                check((duties[i] == 0 || duties[i] == 255) ? "R5 highs" : "R4 highs", h,
                      (duties[i] == 255) ? 256 * (ld + 1) : duties[i] * (ld + 1));
            end
        end

        // R6 limits take effect next cycle
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h0);
        wr(3'd1, 32'd3);
        wr(3'd0, 32'h42);
        wait_xfer(n);
        run_chk("R6 before", 0, 3, 0, 4, h);
        check("R6 low", {31'd0, led_out}, 32'd0);
        wr(3'd1, 32'd200);      // now at k=5
        check("R6 immediate", {31'd0, led_out}, 32'd1);

        // R7 delay write only fills the holding register
        @(negedge clk);         // k=6
        wr(3'd2, 32'd2);        // k=7
        rd(3'd2, v); check("R7 hold readback", v, 32'd2);
        run_chk("R7 active unchanged", 0, 200, 7, 593, h);   // through k=599

        // R8 staged transfer at the next boundary (k=768)
        wr(3'd0, 32'h42);       // k=601
        rd(3'd0, v); check("R8 pending", {31'd0, v[6]}, 32'd1);
        wait_xfer(n);
        check("R8 boundary cycle", n, 32'd167);
        run_chk("R8 new period", 2, 200, 0, 768, h);
        check("R8 highs", h, 32'd600);

        // R9 soft reset
        wr(3'd2, 32'd1);
        wr(3'd0, 32'h42);
        wr(3'd0, 32'h0000_FF86);
        rd(3'd0, v); check("R9 cfg default", v, 32'h0000_1400);
        check("R9 led", {31'd0, led_out}, 32'd0);
        rd(3'd2, v); check("R9 dly kept", v, 32'd1);
        rd(3'd1, v); check("R9 lim kept", v, 32'd200);
        wr(3'd0, 32'h2);
        run_chk("R9 ld cleared", 0, 200, 0, 512, h);
        rd(3'd0, v); check("R9 no transfer", {31'd0, v[6]}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule